// File: doc/BRIEF.md
# Signal-Processing Data Address Generator

This block produces data-memory addresses for a signal-processing datapath. It holds a small bank of pointer registers. Each register carries its own stepping mode: plain linear stepping, circular stepping inside a power-of-two buffer, or reverse-carry stepping that yields the operand order of a radix-2 FFT. Software or a sequencer loads a pointer, its mode and its buffer size through a configuration write.

Each cycle the host may raise a request that names one register, a direction, an offset and an element size. The block returns that register's current address combinationally in the same cycle and stores the stepped pointer at the clock edge. A filter tap or an FFT butterfly can therefore fetch one operand per cycle with no extra update cycles.

Top module: `dsp_agu`

## Requirements
- R1: After a synchronous active-low reset every pointer is 0, every mode is linear and every buffer size is 2^0.
- R2: With req_valid high, addr_out equals the selected pointer's value before the update; the stepped value is visible to a request in the next cycle.
- R3: The step is req_off scaled by the element size: req_esz 0 gives x1, 1 gives x2, 2 and 3 give x4. req_dec=0 adds the step, req_dec=1 subtracts it.
- R4: In linear mode (cfg_mode 0, or the spare code 3) the pointer is stepped over the full 32-bit range and wraps modulo 2^32.
- R5: In circular mode (cfg_mode 1) with size 2^k, only the low k bits change; they wrap modulo 2^k in both directions and the upper bits hold.
- R6: In reverse-carry mode (cfg_mode 2) with size 2^k, the low k bits are stepped with the carry moving from the most significant toward the least significant bit of the field; with a step of 2^(k-1) the index runs 0,4,2,6,1,5,3,7 for k=3. Upper bits hold.
- R7: A configuration write loads pointer, mode and log2 size into the register named by cfg_sel; a request in the next cycle sees the new values.
- R8: When a configuration write and a request name the same register in one cycle, the write wins; the request still returns the old pointer.
- R9: Without a request and without a write no pointer changes, and a request never changes a register it does not select.
- R10: In circular or reverse-carry mode with a log2 size of 0 the pointer holds on every request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register written by the configuration |
| cfg_mode | input | 2 | Stepping mode: 0 linear, 1 circular, 2 reverse-carry, 3 linear |
| cfg_log2sz | input | 5 | log2 of the buffer size in bytes |
| cfg_ptr | input | 32 | Initial pointer value |
| req_valid | input | 1 | Address request |
| req_sel | input | 2 | Register used by the request |
| req_dec | input | 1 | 1 steps downward, 0 steps upward |
| req_off | input | 8 | Unsigned step count |
| req_esz | input | 2 | Element size code: 0 byte, 1 halfword, 2/3 word |
| addr_out | output | 32 | Pointer value before the update |

## Verification
A configuration write and a pointer update can land on the same register in the same cycle. The bench provokes this by loading a register while it also requests that register, and by loading one register while it steps another. It judges the outcome by the address returned in that cycle, which must be the old pointer, and by the address returned by the next request, which must be the newly loaded value for the shared register and the stepped value for the other one.

// File: rtl/agu_pkg.sv
// Shared types for the address generator.
// Assumes the mode code is two bits wide; code 3 behaves as linear.
package agu_pkg;
    typedef enum logic [1:0] {
        STEP_LINEAR  = 2'd0,
        STEP_CIRCLE  = 2'd1,
        STEP_REVERSE = 2'd2,
        STEP_SPARE   = 2'd3
    } step_mode_e;

    typedef struct packed {
        step_mode_e mode;
        logic [4:0] log2sz;
    } ptr_cfg_t;
endpackage

// File: rtl/agu_stepper.sv
// Combinational next-pointer computation for one request.
// Assumes circular and reverse-carry buffers are aligned to their size,
// so the bits at and above log2sz stay fixed while the low field moves.
module agu_stepper #(
    parameter int AW = 32,
    parameter int OW = 8,
    parameter int KW = 5
) (
    input  logic [AW-1:0]         cur,
    input  agu_pkg::step_mode_e   mode,
    input  logic [KW-1:0]         log2sz,
    input  logic [OW-1:0]         off,
    input  logic [1:0]            esz,
    input  logic                  dec,
    output logic [AW-1:0]         nxt
);
    import agu_pkg::*;

    localparam int SW = KW + 1;

    logic [1:0]    scale;
    logic [AW-1:0] step;
    logic [AW-1:0] mask;
    logic [AW-1:0] field;
    logic [AW-1:0] upper;
    logic [AW-1:0] lin_nxt;
    logic [AW-1:0] circ_low;
    logic [SW-1:0] rsh;
    logic [AW-1:0] rev_field;
    logic [AW-1:0] rev_step;
    logic [AW-1:0] rev_sum;
    logic [AW-1:0] rev_low;

    // Mirror a full-width word end to end.
    function automatic logic [AW-1:0] mirror(input logic [AW-1:0] v);
        logic [AW-1:0] r;
        for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
        return r;
    endfunction

    // Scale the offset by the element size.
    always_comb begin
        scale = (esz == 2'd0) ? 2'd0 : (esz == 2'd1) ? 2'd1 : 2'd2;
        step  = AW'(off) << scale;
    end

    // Split the pointer into the fixed upper part and the moving field.
    always_comb begin
        mask  = (AW'(1) << log2sz) - AW'(1);
        field = cur & mask;
        upper = cur & ~mask;
        rsh   = SW'(AW) - SW'(log2sz);
    end

    // Linear and circular candidates.
    always_comb begin
        lin_nxt  = dec ? (cur - step) : (cur + step);
        circ_low = (dec ? (field - step) : (field + step)) & mask;
    end

    // Reverse-carry candidate: mirror the field, add, mirror back.
    always_comb begin
        rev_field = mirror(field) >> rsh;
        rev_step  = mirror(step & mask) >> rsh;
        rev_sum   = (dec ? (rev_field - rev_step) : (rev_field + rev_step)) & mask;
        rev_low   = mirror(rev_sum) >> rsh;
    end

    // Pick the candidate for the register's mode.
    always_comb begin
        case (mode)
            STEP_CIRCLE:  nxt = upper | circ_low;
            STEP_REVERSE: nxt = upper | rev_low;
            default:      nxt = lin_nxt;
        endcase
    end
endmodule

// File: rtl/agu_regbank.sv
// Pointer registers with their per-register mode and size.
// Assumes at most one configuration write and one update per cycle;
// the configuration write wins when both name the same register.
module agu_regbank #(
    parameter int AW   = 32,
    parameter int NREG = 4,
    parameter int KW   = 5,
    localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [RW-1:0]        cfg_sel,
    input  agu_pkg::ptr_cfg_t    cfg_val,
    input  logic [AW-1:0]        cfg_ptr,
    input  logic                 upd_we,
    input  logic [RW-1:0]        upd_sel,
    input  logic [AW-1:0]        upd_ptr,
    input  logic [RW-1:0]        rd_sel,
    output logic [AW-1:0]        rd_ptr,
    output agu_pkg::ptr_cfg_t    rd_cfg
);
    import agu_pkg::*;

    logic [NREG-1:0][AW-1:0] ptr_q;
    ptr_cfg_t                cfg_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic hit_cfg;
        logic hit_upd;
        assign hit_cfg = cfg_we && (cfg_sel == RW'(g));
        assign hit_upd = upd_we && (upd_sel == RW'(g));

        // Hold, load or step one pointer register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_q[g] <= '0;
                cfg_q[g] <= '{mode: STEP_LINEAR, log2sz: '0};
            end else if (hit_cfg) begin
                ptr_q[g] <= cfg_ptr;
                cfg_q[g] <= cfg_val;
            end else if (hit_upd) begin
                ptr_q[g] <= upd_ptr;
            end
        end
    end

    // Read the register named by the request.
    always_comb begin
        rd_ptr = ptr_q[rd_sel];
        rd_cfg = cfg_q[rd_sel];
    end

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && !upd_we) |=> $stable(ptr_q));

    // R8
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (ptr_q[$past(cfg_sel)] == $past(cfg_ptr)));
endmodule

// File: rtl/dsp_agu.sv
// Data address generator top: one request per cycle returns the current
// pointer and writes back the stepped pointer at the clock edge.
// Assumes buffers in circular/reverse modes are aligned to their size.
module dsp_agu #(
    parameter int AW   = 32,
    parameter int NREG = 4,
    parameter int OW   = 8,
    localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int KW  = $clog2(AW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [RW-1:0]   cfg_sel,
    input  logic [1:0]      cfg_mode,
    input  logic [KW-1:0]   cfg_log2sz,
    input  logic [AW-1:0]   cfg_ptr,
    input  logic            req_valid,
    input  logic [RW-1:0]   req_sel,
    input  logic            req_dec,
    input  logic [OW-1:0]   req_off,
    input  logic [1:0]      req_esz,
    output logic [AW-1:0]   addr_out
);
    import agu_pkg::*;

    ptr_cfg_t      cfg_val;
    ptr_cfg_t      sel_cfg;
    logic [AW-1:0] cur_ptr;
    logic [AW-1:0] nxt_ptr;

    // Pack the configuration fields for the bank.
    always_comb begin
        cfg_val.mode   = step_mode_e'(cfg_mode);
        cfg_val.log2sz = cfg_log2sz;
    end

    agu_regbank #(.AW(AW), .NREG(NREG), .KW(KW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .cfg_sel (cfg_sel),
        .cfg_val (cfg_val),
        .cfg_ptr (cfg_ptr),
        .upd_we  (req_valid),
        .upd_sel (req_sel),
        .upd_ptr (nxt_ptr),
        .rd_sel  (req_sel),
        .rd_ptr  (cur_ptr),
        .rd_cfg  (sel_cfg)
    );

    agu_stepper #(.AW(AW), .OW(OW), .KW(KW)) u_step (
        .cur    (cur_ptr),
        .mode   (sel_cfg.mode),
        .log2sz (sel_cfg.log2sz),
        .off    (req_off),
        .esz    (req_esz),
        .dec    (req_dec),
        .nxt    (nxt_ptr)
    );

    // Return the pre-update pointer.
    assign addr_out = cur_ptr;

    // R5 R6
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (sel_cfg.mode == STEP_CIRCLE || sel_cfg.mode == STEP_REVERSE))
        |-> ((nxt_ptr >> sel_cfg.log2sz) == (cur_ptr >> sel_cfg.log2sz)));

    // R10
    unit_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sel_cfg.log2sz == '0 &&
         (sel_cfg.mode == STEP_CIRCLE || sel_cfg.mode == STEP_REVERSE))
        |-> (nxt_ptr == cur_ptr));
endmodule

// File: tb/tb_dsp_agu.sv
module tb_dsp_agu;
    localparam time CLK_HALF = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [1:0]  cfg_mode = '0;
    logic [4:0]  cfg_log2sz = '0;
    logic [31:0] cfg_ptr = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_sel = '0;
    logic        req_dec = 1'b0;
    logic [7:0]  req_off = '0;
    logic [1:0]  req_esz = '0;
    logic [31:0] addr_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #CLK_HALF clk = ~clk;

    dsp_agu dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_mode(cfg_mode),
        .cfg_log2sz(cfg_log2sz), .cfg_ptr(cfg_ptr),
        .req_valid(req_valid), .req_sel(req_sel), .req_dec(req_dec),
        .req_off(req_off), .req_esz(req_esz), .addr_out(addr_out)
    );

    // One cycle of stimulus; a request pushes its expected address.
    task automatic cyc(input bit we, input logic [1:0] cs, input logic [1:0] cm,
                       input logic [4:0] ck, input logic [31:0] cp,
                       input bit rv, input logic [1:0] rs, input bit rd,
                       input logic [7:0] ro, input logic [1:0] re,
                       input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        cfg_we = we; cfg_sel = cs; cfg_mode = cm; cfg_log2sz = ck; cfg_ptr = cp;
        req_valid = rv; req_sel = rs; req_dec = rd; req_off = ro; req_esz = re;
        if (rv) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
    endtask

    task automatic cfg(input logic [1:0] s, input logic [1:0] m,
                       input logic [4:0] k, input logic [31:0] p);
        cyc(1, s, m, k, p, 0, 0, 0, 0, 0, 0, "");
    endtask

    task automatic req(input logic [1:0] s, input bit d, input logic [7:0] o,
                       input logic [1:0] e, input logic [31:0] exp, input string tag);
        cyc(0, 0, 0, 0, 0, 1, s, d, o, e, exp, tag);
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    endtask

    // Monitor: compare each returned address away from the clock edge.
    always @(negedge clk) begin
        if (rst_n && req_valid && !done) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard empty: actual %h expected none", addr_out);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (addr_out !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", t, addr_out, e);
                end
            end
        end
    end

    initial begin
        #(CLK_HALF * 2 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset pointers zero, linear mode
        for (int i = 0; i < 4; i++) req(2'(i), 0, 0, 0, 32'h0, "R1 reset ptr");
        req(0, 0, 4, 0, 32'h0, "R1 linear after reset");
        req(0, 0, 0, 0, 32'h4, "R1 R2 stepped by 4");

        // R3 R7: linear with element scaling, both directions
        cfg(1, 0, 0, 32'h1000);
        req(1, 0, 8, 1, 32'h1000, "R7 loaded ptr");
        req(1, 1, 3, 0, 32'h1010, "R3 inc 8 halfwords");
        req(1, 0, 3, 3, 32'h100D, "R3 dec 3 bytes");
        req(1, 0, 0, 2, 32'h1019, "R3 esz3 scales by 4");

        // R4: full-range wrap both directions
        cfg(3, 3, 7, 32'hFFFF_FFFC);
        req(3, 0, 1, 2, 32'hFFFF_FFFC, "R4 before wrap");
        req(3, 1, 2, 0, 32'h0000_0000, "R4 wrapped up");
        req(3, 0, 0, 0, 32'hFFFF_FFFE, "R4 wrapped down");

        // R5: circular 16-byte buffer with fixed upper bits
        cfg(2, 1, 4, 32'h1234_567C);
        req(2, 0, 1, 2, 32'h1234_567C, "R5 start");
        req(2, 0, 1, 2, 32'h1234_5670, "R5 wrap up");
        req(2, 1, 1, 2, 32'h1234_5674, "R5 step");
        req(2, 1, 2, 2, 32'h1234_5670, "R5 step down");
        req(2, 0, 0, 0, 32'h1234_5678, "R5 wrap down");

        // R6: reverse-carry, size 8, step half size
        cfg(0, 2, 3, 32'h0000_0100);
        req(0, 0, 4, 0, 32'h100, "R6 idx0");
        req(0, 0, 4, 0, 32'h104, "R6 idx4");
        req(0, 0, 4, 0, 32'h102, "R6 idx2");
        req(0, 0, 4, 0, 32'h106, "R6 idx6");
        req(0, 0, 4, 0, 32'h101, "R6 idx1");
        req(0, 0, 4, 0, 32'h105, "R6 idx5");
        req(0, 0, 4, 0, 32'h103, "R6 idx3");
        req(0, 0, 4, 0, 32'h107, "R6 idx7");
        req(0, 1, 4, 0, 32'h100, "R6 wrap to idx0");
        req(0, 0, 0, 0, 32'h107, "R6 decrement from idx0");

        // R10: unit buffer holds in circular and reverse modes
        cfg(1, 1, 0, 32'h77);
        req(1, 0, 5, 2, 32'h77, "R10 circular k0");
        req(1, 0, 0, 0, 32'h77, "R10 circular held");
        cfg(1, 2, 0, 32'h99);
        req(1, 1, 9, 1, 32'h99, "R10 reverse k0");
        req(1, 0, 0, 0, 32'h99, "R10 reverse held");

        // R9: idle cycles and unselected registers keep their pointers
        cfg(1, 0, 0, 32'h500);
        idle(); idle();
        req(1, 0, 0, 0, 32'h500, "R9 idle hold");
        req(3, 0, 0, 0, 32'hFFFF_FFFE, "R9 other reg untouched");

        // R8: write and request on the same register in one cycle
        cyc(1, 1, 0, 0, 32'h900, 1, 1, 0, 1, 0, 32'h500, "R8 old ptr returned");
        req(1, 0, 0, 0, 32'h900, "R8 write wins");
        // write one register while stepping another
        cyc(1, 2, 0, 0, 32'hABC0, 1, 1, 0, 2, 2, 32'h900, "R8 step other reg");
        req(1, 0, 0, 0, 32'h908, "R8 stepped reg");
        req(2, 0, 0, 0, 32'hABC0, "R8 loaded reg");

        idle();
        @(posedge clk);
        done = 1'b1;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard leftover: actual %0d expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule